// File: doc/BRIEF.md
# Sampling Converter Host Bus Front End

This block is the part of a sampling analog-to-digital converter that a microprocessor sees. A host uses active-low chip-select, read and write strobes and a 13-bit data bus, with separate input, output and per-lane output-enable signals, to write one configuration word. It reads conversion results back in one 13-bit access or in two 8-bit accesses. An active-low ready line tells the host when a requested function has finished. A conversion starts when the host writes a start command, or on a rising edge of a SYNC line when SYNC is configured as an input. When SYNC is configured as an output it carries a busy flag. A counter stands in for the converter: it produces a programmed sequence of 13-bit sign-plus-magnitude codes.

The sequencer is one state machine with five states. `ST_IDLE` waits for a start request. `ST_ACQ` counts the programmable acquisition time. `ST_CONV` counts the fixed conversion time. `ST_INIT` runs the reset command sequence. `ST_LOCK` is the test lock, which only the reset pin leaves. Its transitions are:
- start accept: `ST_IDLE` → `ST_ACQ`.
- acquisition done: `ST_ACQ` → `ST_CONV`.
- result ready: `ST_CONV` → `ST_IDLE`.
- init abort: `ST_IDLE`/`ST_ACQ`/`ST_CONV` → `ST_INIT`.
- init done: `ST_INIT` → `ST_IDLE`.
- lock entry: any state → `ST_LOCK`.

The strobe front end samples the bus pins once per clock. It turns the write, read and all-strobes-low windows into single-cycle events.

Top module: `adc_host_if`

## Requirements
- R1: The write-edge strap is taken in the first clock after reset and is held until the next reset. When it is 0, a write stores the data present in the last cycle that write strobe and chip select are both low. When it is 1, a write stores the data present in the first such cycle.
- R2: `bus_oe` is all zero unless `cs_n` and `rd_n` are both low.
- R3: The configuration word has these fields: bit 3 is the wide flag, bit 4 is the SYNC direction (1 = input), bits 8:5 are the acquisition extension, bits 2:0 are the command, and bits 12:9 are reserved. During a read with the wide flag at 1, all 13 lanes are enabled. With the wide flag at 0, only lanes 7:0 are enabled and lanes 12:8 stay disabled.
- R4: With the wide flag at 0, the first read returns result bits 7:0. The second read returns result bits 12:8 with bit 12 copied into lanes 7:5. The byte pointer goes back to the low byte whenever a new result is stored.
- R5: With SYNC as an input, `sync_oe` and `sync_out` are 0, and a rising edge on `sync_in` starts a conversion.
- R6: With SYNC as an output (`sync_oe`=1, the reset value), `sync_out` is high for exactly the acquisition plus conversion cycles of each conversion. The conversion takes 12 cycles.
- R7: The acquisition lasts 9 + (bits 8:5) cycles.
- R8: A start request that arrives while a conversion is running is ignored. It produces no second conversion.
- R9: `rdy_n` is 1 after reset and falls when a result is stored. It rises when a result read completes: after one wide read, or after the second narrow read.
- R10: Command 010 forces `rdy_n` high, aborts any conversion, and drives `rdy_n` low 20 cycles later.
- R11: If the bus sees chip select, read and write all low together, with command 101 or 110 on bits 2:0, then `test_lock` is set. From then on, writes and starts are ignored until `rst_n` is asserted.
- R12: Command codes other than 001 (start) and 010 (init) start nothing and leave `rdy_n` unchanged. A write with any reserved bit set changes nothing at all.
- R13: Stored result k after reset (counting from 0) is 0x0123 + k·0x1A5B modulo 2^13. Bit 12 is the most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_edge_sel | input | 1 | Write-edge strap, taken after reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 13 | Data from host |
| bus_out | output | 13 | Data to host |
| bus_oe | output | 13 | Per-lane output enable |
| sync_in | input | 1 | SYNC pin input value |
| sync_out | output | 1 | SYNC busy flag |
| sync_oe | output | 1 | SYNC drives when 1 |
| rdy_n | output | 1 | Ready, active low |
| test_lock | output | 1 | Test lock active |

## Verification
Two functions can meet in the same cycle: a start request arriving while a conversion is busy, and the end of a conversion arriving together with the completion of a result read. The bench provokes the first by issuing a second start write during the acquisition window. It then judges that exactly one busy pulse of the expected width appeared and that the stored result sequence advanced by one. The second case is covered by checking that `rdy_n` falls only together with `sync_out` falling, and that after a partial narrow read a new result is always read from its low byte.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_CONV,
        ST_INIT,
        ST_LOCK
    } seq_state_e;

    localparam logic [2:0] CMD_START  = 3'b001;
    localparam logic [2:0] CMD_INIT   = 3'b010;
    localparam logic [2:0] CMD_TEST_A = 3'b101;
    localparam logic [2:0] CMD_TEST_B = 3'b110;

    localparam int CMD_W     = 3;
    localparam int WIDE_BIT  = 3;
    localparam int SDIR_BIT  = 4;
    localparam int ACQ_LSB   = 5;

endpackage

// File: rtl/adc_bus_port.sv
module adc_bus_port
    import adc_host_pkg::*;
#(
    parameter int DW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] d_in,
    output logic          wr_evt,
    output logic [DW-1:0] wr_data,
    output logic          test_evt,
    output logic          rd_end
);

    logic          strap_taken;
    logic          fall_mode;
    logic          wr_q, wr_qq;
    logic          rd_q, rd_qq;
    logic          all_q, all_qq;
    logic [DW-1:0] d_q, d_qq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_taken <= 1'b0;
            fall_mode   <= 1'b0;
            wr_q        <= 1'b0;
            wr_qq       <= 1'b0;
            rd_q        <= 1'b0;
            rd_qq       <= 1'b0;
            all_q       <= 1'b0;
            all_qq      <= 1'b0;
            d_q         <= '0;
            d_qq        <= '0;
        end else begin
            if (!strap_taken) begin
                fall_mode   <= strap;
                strap_taken <= 1'b1;
            end
            wr_q   <= !cs_n && !wr_n && rd_n;
            wr_qq  <= wr_q;
            rd_q   <= !cs_n && !rd_n && wr_n;
            rd_qq  <= rd_q;
            all_q  <= !cs_n && !rd_n && !wr_n;
            all_qq <= all_q;
            d_q    <= d_in;
            d_qq   <= d_q;
        end
    end

    always_comb begin
        if (fall_mode) begin
            wr_evt  = wr_q && !wr_qq;
            wr_data = d_q;
        end else begin
            wr_evt  = !wr_q && wr_qq;
            wr_data = d_qq;
        end
        test_evt = all_q && !all_qq &&
                   ((d_q[CMD_W-1:0] == CMD_TEST_A) || (d_q[CMD_W-1:0] == CMD_TEST_B));
        rd_end   = rd_qq && !rd_q;
    end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_host_pkg::*;
#(
    parameter int          DW        = 13,
    parameter int          AW        = 4,
    parameter int          ACQ_BASE  = 9,
    parameter int          CONV_CLKS = 12,
    parameter int          INIT_CLKS = 20,
    parameter logic [12:0] SEED      = 13'h0123,
    parameter logic [12:0] STEP      = 13'h1A5B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_evt,
    input  logic [DW-1:0] wr_data,
    input  logic          test_evt,
    input  logic          rd_end,
    input  logic          sync_in,
    output logic          cfg_wide,
    output logic          cfg_sync_in,
    output logic [DW-1:0] result,
    output logic          byte_hi,
    output logic          rdy_n,
    output logic          busy,
    output logic          locked
);

    localparam int RSV_LSB  = ACQ_LSB + AW;
    localparam int ACQ_MAX  = ACQ_BASE + (1 << AW) - 1;
    localparam int LONG_A   = (ACQ_MAX > CONV_CLKS) ? ACQ_MAX : CONV_CLKS;
    localparam int LONGEST  = (LONG_A > INIT_CLKS) ? LONG_A : INIT_CLKS;
    localparam int CW       = $clog2(LONGEST + 1);

    seq_state_e    state, state_nx;
    logic [CW-1:0] cnt;
    logic [CW-1:0] acq_last;
    logic [AW-1:0] cfg_acq;
    logic [DW-1:0] acc;
    logic [2:0]    sync_sh;
    logic          wr_ok, cmd_start, cmd_init, sync_rise, start_req;
    logic          conv_done, init_done, init_enter;

    // decode of host writes
    always_comb begin
        wr_ok      = wr_evt && (wr_data[DW-1:RSV_LSB] == '0) && (state != ST_LOCK);
        cmd_start  = wr_ok && (wr_data[CMD_W-1:0] == CMD_START);
        cmd_init   = wr_ok && (wr_data[CMD_W-1:0] == CMD_INIT);
        sync_rise  = cfg_sync_in && sync_sh[1] && !sync_sh[2];
        start_req  = cmd_start || sync_rise;
        acq_last   = CW'(ACQ_BASE - 1) + CW'(cfg_acq);
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_init)       state_nx = ST_INIT;
                else if (start_req) state_nx = ST_ACQ;
            end
            ST_ACQ: begin
                if (cmd_init)              state_nx = ST_INIT;
                else if (cnt == acq_last)  state_nx = ST_CONV;
            end
            ST_CONV: begin
                if (cmd_init)                        state_nx = ST_INIT;
                else if (cnt == CW'(CONV_CLKS - 1))  state_nx = ST_IDLE;
            end
            ST_INIT: begin
                if (cnt == CW'(INIT_CLKS - 1)) state_nx = ST_IDLE;
            end
            ST_LOCK: state_nx = ST_LOCK;
            default: state_nx = ST_IDLE;
        endcase
        if (test_evt) state_nx = ST_LOCK;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs of the state machine
    always_comb begin
        busy       = (state == ST_ACQ) || (state == ST_CONV);
        locked     = (state == ST_LOCK);
        conv_done  = (state == ST_CONV) && (state_nx == ST_IDLE);
        init_done  = (state == ST_INIT) && (state_nx == ST_IDLE);
        init_enter = (state != ST_INIT) && (state_nx == ST_INIT);
    end

    // phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if ((state_nx != state) || (state == ST_IDLE) || (state == ST_LOCK)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // configuration and SYNC input sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_wide    <= 1'b0;
            cfg_sync_in <= 1'b0;
            cfg_acq     <= '0;
            sync_sh     <= '0;
        end else begin
            sync_sh <= {sync_sh[1:0], sync_in};
            if (wr_ok) begin
                cfg_wide    <= wr_data[WIDE_BIT];
                cfg_sync_in <= wr_data[SDIR_BIT];
                cfg_acq     <= wr_data[ACQ_LSB +: AW];
            end
        end
    end

    // result, byte pointer and ready
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            acc     <= DW'(SEED);
            byte_hi <= 1'b0;
            rdy_n   <= 1'b1;
        end else if (conv_done) begin
            result  <= acc;
            acc     <= acc + DW'(STEP);
            byte_hi <= 1'b0;
            rdy_n   <= 1'b0;
        end else if (init_enter) begin
            byte_hi <= 1'b0;
            rdy_n   <= 1'b1;
        end else if (init_done) begin
            rdy_n   <= 1'b0;
        end else if (rd_end && !locked) begin
            if (cfg_wide || byte_hi) begin
                byte_hi <= 1'b0;
                rdy_n   <= 1'b1;
            end else begin
                byte_hi <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_rd_mux.sv
module adc_rd_mux #(
    parameter int DW   = 13,
    parameter int LO_W = 8
) (
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wide,
    input  logic          byte_hi,
    input  logic [DW-1:0] result,
    output logic [DW-1:0] d_out,
    output logic [DW-1:0] d_oe
);

    localparam int HI_W  = DW - LO_W;
    localparam int EXT_W = LO_W - HI_W;

    logic rd_on;
    logic [LO_W-1:0] narrow_byte;

    always_comb begin
        rd_on = !cs_n && !rd_n;
        if (byte_hi) narrow_byte = {{EXT_W{result[DW-1]}}, result[DW-1:LO_W]};
        else         narrow_byte = result[LO_W-1:0];
        if (wide) d_out = result;
        else      d_out = {{HI_W{1'b0}}, narrow_byte};
    end

    for (genvar i = 0; i < DW; i++) begin : g_lane
        if (i < LO_W) begin : g_low
            assign d_oe[i] = rd_on;
        end else begin : g_high
            assign d_oe[i] = rd_on && wide;
        end
    end

endmodule

// File: rtl/adc_host_if.sv
module adc_host_if #(
    parameter int          DW        = 13,
    parameter int          LO_W      = 8,
    parameter int          AW        = 4,
    parameter int          ACQ_BASE  = 9,
    parameter int          CONV_CLKS = 12,
    parameter int          INIT_CLKS = 20,
    parameter logic [12:0] SEED      = 13'h0123,
    parameter logic [12:0] STEP      = 13'h1A5B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_edge_sel,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic [DW-1:0] bus_oe,
    input  logic          sync_in,
    output logic          sync_out,
    output logic          sync_oe,
    output logic          rdy_n,
    output logic          test_lock
);

    logic          wr_evt, test_evt, rd_end;
    logic [DW-1:0] wr_data;
    logic          cfg_wide, cfg_sync_in, byte_hi, busy;
    logic [DW-1:0] result;

    adc_bus_port #(.DW(DW)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap    (wr_edge_sel),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .d_in     (bus_in),
        .wr_evt   (wr_evt),
        .wr_data  (wr_data),
        .test_evt (test_evt),
        .rd_end   (rd_end)
    );

    adc_conv_seq #(
        .DW(DW), .AW(AW), .ACQ_BASE(ACQ_BASE), .CONV_CLKS(CONV_CLKS),
        .INIT_CLKS(INIT_CLKS), .SEED(SEED), .STEP(STEP)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_evt      (wr_evt),
        .wr_data     (wr_data),
        .test_evt    (test_evt),
        .rd_end      (rd_end),
        .sync_in     (sync_in),
        .cfg_wide    (cfg_wide),
        .cfg_sync_in (cfg_sync_in),
        .result      (result),
        .byte_hi     (byte_hi),
        .rdy_n       (rdy_n),
        .busy        (busy),
        .locked      (test_lock)
    );

    adc_rd_mux #(.DW(DW), .LO_W(LO_W)) u_mux (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wide    (cfg_wide),
        .byte_hi (byte_hi),
        .result  (result),
        .d_out   (bus_out),
        .d_oe    (bus_oe)
    );

    always_comb begin
        sync_oe  = !cfg_sync_in;
        sync_out = busy && !cfg_sync_in;
    end

endmodule

// File: rtl/adc_host_if_chk.sv
module adc_host_if_chk #(
    parameter int DW   = 13,
    parameter int LO_W = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic [DW-1:0] bus_oe,
    input logic          sync_out,
    input logic          sync_oe,
    input logic          rdy_n,
    input logic          test_lock
);

    assert_oe_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (bus_oe == '0));

    assert_upper_lanes_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe[DW-1:LO_W] != '0) |-> (&bus_oe));

    assert_sync_quiet_as_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_oe |-> !sync_out);

    assert_ready_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> !sync_out);

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(test_lock) |-> test_lock);

endmodule

bind adc_host_if adc_host_if_chk #(.DW(DW), .LO_W(LO_W)) chk_i (.*);

// File: tb/adc_host_if_tb_top.sv
module adc_host_if_tb_top;

    localparam logic [12:0] SEED  = 13'h0123;
    localparam logic [12:0] STEP  = 13'h1A5B;
    localparam int          CONV  = 12;
    localparam int          BASE  = 9;

    logic        clk = 1'b0;
    logic        rst_n, wr_edge_sel, cs_n, rd_n, wr_n, sync_in;
    logic [12:0] bus_in, bus_out, bus_oe;
    logic        sync_out, sync_oe, rdy_n, test_lock;

    always #2 clk = ~clk;

    adc_host_if dut_i (
        .clk(clk), .rst_n(rst_n), .wr_edge_sel(wr_edge_sel), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .sync_in(sync_in), .sync_out(sync_out),
        .sync_oe(sync_oe), .rdy_n(rdy_n), .test_lock(test_lock)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int run_len  = 0;
    int last_w   = 0;
    int n_pulses = 0;
    int k_next   = 0;
    logic [12:0] exp_q[$];

    // monitor of SYNC busy pulses
    always @(negedge clk) begin
        if (sync_out === 1'b1) run_len++;
        else if (run_len != 0) begin
            last_w = run_len;
            n_pulses++;
            run_len = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_exp();
        exp_q.push_back(SEED + 13'(k_next * int'(STEP)));
        k_next++;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; wr_edge_sel = strap;
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; bus_in = '0; sync_in = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(3);
        k_next = 0;
        exp_q.delete();
    endtask

    task automatic bus_write(input logic [12:0] a, input logic [12:0] b);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; bus_in = a;
        tick(2);
        bus_in = b;
        tick(2);
        cs_n = 1'b1; wr_n = 1'b1;
        tick(4);
    endtask

    task automatic bus_read(output logic [12:0] data, output logic [12:0] oe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        tick(2);
        data = bus_out; oe = bus_oe;
        cs_n = 1'b1; rd_n = 1'b1;
        tick(3);
    endtask

    // driver: issue a start and record the expected result
    task automatic start_conv(input logic [12:0] word);
        push_exp();
        bus_write(word, word);
    endtask

    task automatic wait_pulses(input int target);
        for (int i = 0; i < 300 && n_pulses < target; i++) tick(1);
    endtask

    task automatic wait_rdy_low();
        for (int i = 0; i < 300 && rdy_n !== 1'b0; i++) tick(1);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [12:0] d, oe, e;
        int p0;

        do_reset(1'b0);
        // reset state
        check("R9 rdy after reset", 32'(rdy_n), 32'd1);
        check("R6 sync dir after reset", 32'(sync_oe), 32'd1);
        check("R6 sync idle after reset", 32'(sync_out), 32'd0);
        check("R11 lock after reset", 32'(test_lock), 32'd0);
        check("R2 oe after reset", 32'(bus_oe), 32'd0);

        // wide conversion
        p0 = n_pulses;
        start_conv(13'h0009);
        wait_pulses(p0 + 1);
        check("R6 busy width", 32'(last_w), 32'(BASE + CONV));
        check("R9 rdy on result", 32'(rdy_n), 32'd0);
        bus_read(d, oe);
        e = exp_q.pop_front();
        check("R3 wide lanes", 32'(oe), 32'h1FFF);
        check("R13 wide result", 32'(d), 32'(e));
        check("R9 rdy after wide read", 32'(rdy_n), 32'd1);

        // select without read strobe
        @(negedge clk); cs_n = 1'b0; tick(1);
        check("R2 no drive without read", 32'(bus_oe), 32'd0);
        cs_n = 1'b1; tick(1);

        // narrow conversion, sign-extended high byte
        p0 = n_pulses;
        start_conv(13'h0001);
        wait_pulses(p0 + 1);
        e = exp_q.pop_front();
        bus_read(d, oe);
        check("R3 narrow lanes", 32'(oe), 32'h00FF);
        check("R4 low byte", 32'(d), 32'(e[7:0]));
        check("R9 rdy after first byte", 32'(rdy_n), 32'd0);
        bus_read(d, oe);
        check("R4 high byte", 32'(d), 32'({{3{e[12]}}, e[12:8]}));
        check("R9 rdy after second byte", 32'(rdy_n), 32'd1);

        // acquisition extension of 3
        p0 = n_pulses;
        start_conv(13'h0069);
        wait_pulses(p0 + 1);
        check("R7 extended acquisition", 32'(last_w), 32'(BASE + 3 + CONV));
        bus_read(d, oe);
        e = exp_q.pop_front();
        check("R13 third result", 32'(d), 32'(e));

        // start during busy is ignored
        p0 = n_pulses;
        start_conv(13'h0009);
        bus_write(13'h0009, 13'h0009);
        wait_pulses(p0 + 1);
        tick(60);
        check("R8 one pulse only", 32'(n_pulses - p0), 32'd1);
        check("R8 pulse width", 32'(last_w), 32'(BASE + CONV));
        bus_read(d, oe);
        e = exp_q.pop_front();
        check("R8 sequence advanced once", 32'(d), 32'(e));

        // undefined command and reserved bits
        p0 = n_pulses;
        bus_write(13'h000F, 13'h000F);
        tick(60);
        check("R12 undefined code no start", 32'(n_pulses - p0), 32'd0);
        check("R12 undefined code rdy", 32'(rdy_n), 32'd1);
        bus_write(13'h0201, 13'h0201);
        tick(60);
        check("R12 reserved no start", 32'(n_pulses - p0), 32'd0);
        bus_read(d, oe);
        check("R12 reserved keeps width", 32'(oe), 32'h1FFF);

        // SYNC as input
        bus_write(13'h0018, 13'h0018);
        check("R5 sync not driven", 32'(sync_oe), 32'd0);
        p0 = n_pulses;
        push_exp();
        @(negedge clk); sync_in = 1'b1; tick(3); sync_in = 1'b0;
        wait_rdy_low();
        check("R5 sync edge starts", 32'(rdy_n), 32'd0);
        check("R5 no busy output", 32'(n_pulses - p0), 32'd0);
        bus_read(d, oe);
        e = exp_q.pop_front();
        check("R5 result", 32'(d), 32'(e));
        bus_write(13'h0000, 13'h0000);

        // pointer reset by new result
        p0 = n_pulses;
        start_conv(13'h0001);
        wait_pulses(p0 + 1);
        bus_read(d, oe);
        void'(exp_q.pop_front());
        start_conv(13'h0001);
        wait_pulses(p0 + 2);
        e = exp_q.pop_front();
        bus_read(d, oe);
        check("R4 pointer reset", 32'(d), 32'(e[7:0]));
        bus_read(d, oe);

        // init command
        p0 = n_pulses;
        start_conv(13'h0009);
        wait_pulses(p0 + 1);
        check("R10 result pending", 32'(rdy_n), 32'd0);
        bus_write(13'h000A, 13'h000A);
        check("R10 rdy forced high", 32'(rdy_n), 32'd1);
        tick(30);
        check("R10 rdy low after init", 32'(rdy_n), 32'd0);

        // test lock
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; bus_in = 13'h0005;
        tick(2);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        tick(3);
        check("R11 lock entered", 32'(test_lock), 32'd1);
        p0 = n_pulses;
        bus_write(13'h0009, 13'h0009);
        tick(60);
        check("R11 start ignored", 32'(n_pulses - p0), 32'd0);
        check("R11 lock held", 32'(test_lock), 32'd1);
        do_reset(1'b1);
        check("R11 lock cleared", 32'(test_lock), 32'd0);

        // write edge strap
        bus_write(13'h0008, 13'h0000);
        bus_read(d, oe);
        check("R1 first-cycle data", 32'(oe), 32'h1FFF);
        do_reset(1'b0);
        bus_write(13'h0008, 13'h0000);
        bus_read(d, oe);
        check("R1 last-cycle data", 32'(oe), 32'h00FF);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule